// File: doc/BRIEF.md
# Floating-point doubleword store unit

This unit executes the four store-double instructions of a 32-bit big-endian load/store architecture. It takes one instruction word per handshake and decodes it. It fetches the base register, the index register and the floating-point source register through a request/valid read port. It then emits one 8-byte memory write that carries the source register bit for bit. The two update variants also write the effective address back to the base register. A reservation-invalidate pulse goes out with the store when reservation tracking is enabled and a reservation is held.

Instructions the unit cannot execute do not reach memory. These are unknown encodings, any store issued while the floating-point unit is disabled, and update forms that name register 0 as base. Each of them raises exactly one flag for one cycle, and the unit is ready for the next instruction at once. The unit has no connection to the condition register or to floating-point status, so it cannot change them.

Top module: `fp_dword_store`

## Requirements
- R1: Bit numbering counts from the MSB, so bit 0 is `in_instr[31]`. Primary opcode 54 (`in_instr[31:26]`) is the displacement form and 55 is the displacement-with-update form. The source FPR is `in_instr[25:21]`, the base RA is `in_instr[20:16]` and the signed 16-bit displacement is `in_instr[15:0]`.
- R2: Primary opcode 31 with extended opcode `in_instr[10:1]` = 727 is the indexed form, and with 759 it is the indexed-with-update form. These forms are recognised only when `in_instr[0]` is 0. RB is `in_instr[15:11]`.
- R3: In the two non-update forms, an RA field of 0 makes the base literal zero, whatever value the read port returns.
- R4: The effective address is base plus the sign-extended displacement (or plus RB), added in 64 bits with wraparound and truncated to 32 bits. Unaligned addresses raise no flag.
- R5: `mem_wr_data` equals the FPR value unchanged, signalling NaNs included. Bits 63:56 are the byte at `mem_wr_addr` and bits 7:0 are the byte at `mem_wr_addr`+7.
- R6: The update forms assert `wb_valid` with `wb_idx` = RA and `wb_data` = the zero-extended effective address. The non-update forms never assert `wb_valid`.
- R7: An update form with RA = 0 (and `fp_en` high) raises `exc_invalid_form` for one cycle. It issues no register read, no store and no writeback.
- R8: A recognised form accepted while `fp_en` is low raises `exc_fp_unavail` for one cycle, with no read, store, writeback or invalidate.
- R9: A store raises `resv_inv_valid` with `resv_inv_addr` equal to the store address exactly when `resv_en` and `resv_active` are both high.
- R10: An unrecognised word raises only `exc_illegal` for one cycle. The flag priority is illegal, then FP-unavailable, then invalid-form.
- R11: `in_ready` is high only when the unit is idle. `rd_req` stays high until `rd_valid`. The memory write, writeback and invalidate appear together for one cycle, in the cycle after the `rd_valid` edge.
- R12: After reset all pulse outputs are low, `rd_req` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit idle, instruction accepted on this edge |
| in_instr | input | 32 | Instruction word |
| fp_en | input | 1 | Floating-point unit enabled |
| rd_req | output | 1 | Register read request |
| rd_gpr_a_idx | output | 5 | Base register index |
| rd_gpr_b_idx | output | 5 | Index register index |
| rd_fpr_idx | output | 5 | Source FPR index |
| rd_valid | input | 1 | Read data valid |
| rd_gpr_a | input | 64 | Base register value |
| rd_gpr_b | input | 64 | Index register value |
| rd_fpr | input | 64 | Source FPR value |
| resv_en | input | 1 | Reservation tracking enabled |
| resv_active | input | 1 | A reservation is held |
| mem_wr_valid | output | 1 | Doubleword write strobe |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 64 | Write data, MSB byte at lowest address |
| wb_valid | output | 1 | Base register writeback |
| wb_idx | output | 5 | Writeback register index |
| wb_data | output | 64 | Writeback value |
| resv_inv_valid | output | 1 | Reservation invalidate pulse |
| resv_inv_addr | output | 32 | Invalidate address |
| exc_invalid_form | output | 1 | Update form with RA = 0 |
| exc_fp_unavail | output | 1 | Floating-point unavailable |
| exc_illegal | output | 1 | Unrecognised instruction |

## Verification
The bench sweeps all four forms over base registers 0, 1 and 31, and over bases and offsets chosen to hit zero, negative displacements, 32-bit wraparound and odd addresses. Register 0 is loaded with a nonzero value, so a base-zero substitution is told apart from a real register read, and update forms are told apart from non-update forms. FPR patterns include a signalling NaN and negative zero to expose any reformatting. The reservation inputs cycle through all four combinations. Near-miss encodings (adjacent opcodes, adjacent extended opcodes, Rc set) and disabled-FPU cases separate the three flags and their priority.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
  localparam int unsigned OPC_W = 6;
  localparam int unsigned XO_W  = 10;
  localparam int unsigned RIDX_W = 5;
  localparam logic [OPC_W-1:0] OPC_DISP   = 6'd54;
  localparam logic [OPC_W-1:0] OPC_DISP_U = 6'd55;
  localparam logic [OPC_W-1:0] OPC_EXT    = 6'd31;
  localparam logic [XO_W-1:0]  XO_IDX     = 10'd727;
  localparam logic [XO_W-1:0]  XO_IDX_U   = 10'd759;

  typedef enum logic [2:0] {
    FORM_NONE, FORM_DISP, FORM_DISP_U, FORM_IDX, FORM_IDX_U
  } fpst_form_e;

  typedef struct packed {
    fpst_form_e          form;
    logic [RIDX_W-1:0]   fs;
    logic [RIDX_W-1:0]   ra;
    logic [RIDX_W-1:0]   rb;
    logic [15:0]         disp;
  } fpst_dec_t;
endpackage

// File: rtl/fpst_decode.sv
module fpst_decode
  import fpst_pkg::*;
(
  input  logic [31:0] instr,
  output fpst_dec_t   dec,
  output logic        recog,
  output logic        upd
);
  logic [OPC_W-1:0] opc;
  logic [XO_W-1:0]  xo;
  logic             rc;

  assign opc = instr[31:26];
  assign xo  = instr[10:1];
  assign rc  = instr[0];

  always_comb begin
    dec.fs   = instr[25:21];
    dec.ra   = instr[20:16];
    dec.rb   = instr[15:11];
    dec.disp = instr[15:0];
    dec.form = FORM_NONE;
    if (opc == OPC_DISP)        dec.form = FORM_DISP;
    else if (opc == OPC_DISP_U) dec.form = FORM_DISP_U;
    else if (opc == OPC_EXT && !rc) begin
      if (xo == XO_IDX)        dec.form = FORM_IDX;
      else if (xo == XO_IDX_U) dec.form = FORM_IDX_U;
    end
  end

  assign recog = (dec.form != FORM_NONE);
  assign upd   = (dec.form == FORM_DISP_U) || (dec.form == FORM_IDX_U);
endmodule

// File: rtl/fpst_agen.sv
module fpst_agen
  import fpst_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 32
) (
  input  fpst_dec_t        dec,
  input  logic [XLEN-1:0]  gpr_a,
  input  logic [XLEN-1:0]  gpr_b,
  output logic [AW-1:0]    ea
);
  localparam int unsigned DISP_W = 16;
  logic [XLEN-1:0] base, offs, sum;
  logic            zero_base;

  assign zero_base = (dec.ra == '0) &&
                     (dec.form == FORM_DISP || dec.form == FORM_IDX);
  assign base = zero_base ? '0 : gpr_a;
  assign offs = (dec.form == FORM_IDX || dec.form == FORM_IDX_U) ? gpr_b :
                {{(XLEN-DISP_W){dec.disp[DISP_W-1]}}, dec.disp};
  assign sum  = base + offs;
  assign ea   = sum[AW-1:0];
endmodule

// File: rtl/fp_dword_store.sv
module fp_dword_store
  import fpst_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 32,
  parameter int unsigned FLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_instr,
  input  logic            fp_en,
  output logic            rd_req,
  output logic [4:0]      rd_gpr_a_idx,
  output logic [4:0]      rd_gpr_b_idx,
  output logic [4:0]      rd_fpr_idx,
  input  logic            rd_valid,
  input  logic [XLEN-1:0] rd_gpr_a,
  input  logic [XLEN-1:0] rd_gpr_b,
  input  logic [FLEN-1:0] rd_fpr,
  input  logic            resv_en,
  input  logic            resv_active,
  output logic            mem_wr_valid,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [FLEN-1:0] mem_wr_data,
  output logic            wb_valid,
  output logic [4:0]      wb_idx,
  output logic [XLEN-1:0] wb_data,
  output logic            resv_inv_valid,
  output logic [AW-1:0]   resv_inv_addr,
  output logic            exc_invalid_form,
  output logic            exc_fp_unavail,
  output logic            exc_illegal
);
  typedef enum logic {S_IDLE, S_READ} st_e;

  st_e       state;
  fpst_dec_t dec, dec_q;
  logic      recog, upd, upd_q;
  logic [AW-1:0] ea;

  fpst_decode u_dec (.instr(in_instr), .dec(dec), .recog(recog), .upd(upd));

  fpst_agen #(.XLEN(XLEN), .AW(AW)) u_agen (
    .dec(dec_q), .gpr_a(rd_gpr_a), .gpr_b(rd_gpr_b), .ea(ea)
  );

  assign in_ready     = (state == S_IDLE);
  assign rd_req       = (state == S_READ);
  assign rd_gpr_a_idx = dec_q.ra;
  assign rd_gpr_b_idx = dec_q.rb;
  assign rd_fpr_idx   = dec_q.fs;

  always_ff @(posedge clk) begin
    if (rst) begin
      state            <= S_IDLE;
      dec_q            <= '0;
      upd_q            <= 1'b0;
      mem_wr_valid     <= 1'b0;
      mem_wr_addr      <= '0;
      mem_wr_data      <= '0;
      wb_valid         <= 1'b0;
      wb_idx           <= '0;
      wb_data          <= '0;
      resv_inv_valid   <= 1'b0;
      resv_inv_addr    <= '0;
      exc_invalid_form <= 1'b0;
      exc_fp_unavail   <= 1'b0;
      exc_illegal      <= 1'b0;
    end else begin
      mem_wr_valid     <= 1'b0;
      wb_valid         <= 1'b0;
      resv_inv_valid   <= 1'b0;
      exc_invalid_form <= 1'b0;
      exc_fp_unavail   <= 1'b0;
      exc_illegal      <= 1'b0;
      case (state)
        S_IDLE: begin
          if (in_valid) begin
            if (!recog)                     exc_illegal      <= 1'b1;
            else if (!fp_en)                exc_fp_unavail   <= 1'b1;
            else if (upd && dec.ra == '0)   exc_invalid_form <= 1'b1;
            else begin
              dec_q <= dec;
              upd_q <= upd;
              state <= S_READ;
            end
          end
        end
        S_READ: begin
          if (rd_valid) begin
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= ea;
            mem_wr_data  <= rd_fpr;
            if (upd_q) begin
              wb_valid <= 1'b1;
              wb_idx   <= dec_q.ra;
              wb_data  <= {{(XLEN-AW){1'b0}}, ea};
            end
            if (resv_en && resv_active) begin
              resv_inv_valid <= 1'b1;
              resv_inv_addr  <= ea;
            end
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpst_checks.sv
module fpst_checks #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned AW   = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            rd_req,
  input logic            rd_valid,
  input logic            mem_wr_valid,
  input logic [AW-1:0]   mem_wr_addr,
  input logic            wb_valid,
  input logic [4:0]      wb_idx,
  input logic [XLEN-1:0] wb_data,
  input logic            resv_inv_valid,
  input logic [AW-1:0]   resv_inv_addr,
  input logic            exc_invalid_form,
  input logic            exc_fp_unavail,
  input logic            exc_illegal
);
  a_r6_wb_carries_addr: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> mem_wr_valid && wb_data == {{(XLEN-AW){1'b0}}, mem_wr_addr});
  a_r7_wb_idx_nonzero: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wb_idx != 5'd0);
  a_r9_inv_matches_store: assert property (@(posedge clk) disable iff (rst)
    resv_inv_valid |-> mem_wr_valid && resv_inv_addr == mem_wr_addr);
  a_r8_flags_block_store: assert property (@(posedge clk) disable iff (rst)
    (exc_invalid_form || exc_fp_unavail || exc_illegal) |->
      !mem_wr_valid && !wb_valid && !resv_inv_valid);
  a_r10_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_invalid_form, exc_fp_unavail, exc_illegal}));
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |=> !mem_wr_valid);
  a_r11_req_held: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_valid |=> rd_req);
  a_r11_store_after_grant: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> $past(rd_req && rd_valid));
  a_r11_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !in_ready);
endmodule

bind fp_dword_store fpst_checks #(.XLEN(XLEN), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .rd_req(rd_req),
  .rd_valid(rd_valid), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
  .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
  .resv_inv_valid(resv_inv_valid), .resv_inv_addr(resv_inv_addr),
  .exc_invalid_form(exc_invalid_form), .exc_fp_unavail(exc_fp_unavail),
  .exc_illegal(exc_illegal)
);

// File: tb/tb_fp_dword_store.sv
module tb_fp_dword_store;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, fp_en;
  logic [31:0] in_instr;
  logic        rd_req, rd_valid;
  logic [4:0]  rd_gpr_a_idx, rd_gpr_b_idx, rd_fpr_idx;
  logic [63:0] rd_gpr_a, rd_gpr_b, rd_fpr;
  logic        resv_en, resv_active;
  logic        mem_wr_valid, wb_valid, resv_inv_valid;
  logic [31:0] mem_wr_addr, resv_inv_addr;
  logic [63:0] mem_wr_data, wb_data;
  logic [4:0]  wb_idx;
  logic        exc_invalid_form, exc_fp_unavail, exc_illegal;

  logic [63:0] gpr [32];
  logic [63:0] fpr [32];
  int nvec = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_dword_store dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int form, input logic [4:0] fs, input logic [4:0] ra,
                                     input logic [4:0] rb, input logic [15:0] d);
    case (form)
      0: mk = {6'd54, fs, ra, d};
      1: mk = {6'd55, fs, ra, d};
      2: mk = {6'd31, fs, ra, rb, 10'd727, 1'b0};
      default: mk = {6'd31, fs, ra, rb, 10'd759, 1'b0};
    endcase
  endfunction

  // form: 0 disp, 1 disp-update, 2 indexed, 3 indexed-update, 4 unrecognised
  task automatic apply(input int form, input logic [31:0] ins, input logic fpen,
                       input logic ren, input logic ract);
    logic [4:0] fs, ra, rb;
    logic [15:0] d;
    logic upd, idx, e_ill, e_fpu, e_inv, stores;
    logic [63:0] base, off, sum;
    logic [31:0] ea;
    fs = ins[25:21]; ra = ins[20:16]; rb = ins[15:11]; d = ins[15:0];
    upd = (form == 1 || form == 3);
    idx = (form == 2 || form == 3);
    e_ill = (form == 4);
    e_fpu = !e_ill && !fpen;
    e_inv = !e_ill && fpen && upd && ra == 5'd0;
    stores = !(e_ill || e_fpu || e_inv);
    base = (!upd && ra == 5'd0) ? 64'd0 : gpr[ra];
    off  = idx ? gpr[rb] : {{48{d[15]}}, d};
    sum  = base + off;
    ea   = sum[31:0];

    @(negedge clk);
    chk(in_ready === 1'b1, "R11 ready when idle", {63'd0, in_ready}, 64'd1);
    in_valid = 1'b1; in_instr = ins; fp_en = fpen; resv_en = ren; resv_active = ract;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    if (!stores) begin
      chk(exc_illegal === e_ill, "R10 illegal flag", {63'd0, exc_illegal}, {63'd0, e_ill});
      chk(exc_fp_unavail === e_fpu, "R8 fp unavailable flag", {63'd0, exc_fp_unavail}, {63'd0, e_fpu});
      chk(exc_invalid_form === e_inv, "R7 invalid form flag", {63'd0, exc_invalid_form}, {63'd0, e_inv});
      chk(rd_req === 1'b0 && mem_wr_valid === 1'b0 && wb_valid === 1'b0 && resv_inv_valid === 1'b0,
          "R7 R8 R10 nothing issued", {60'd0, rd_req, mem_wr_valid, wb_valid, resv_inv_valid}, 64'd0);
    end else begin
      chk(rd_req === 1'b1, "R11 read request", {63'd0, rd_req}, 64'd1);
      chk(rd_gpr_a_idx === ra && rd_fpr_idx === fs, "R1 R2 field extract",
          {54'd0, rd_gpr_a_idx, rd_fpr_idx}, {54'd0, ra, fs});
      if (idx) chk(rd_gpr_b_idx === rb, "R2 RB field", {59'd0, rd_gpr_b_idx}, {59'd0, rb});
      // hold off one cycle to test R11 request hold
      @(negedge clk);
      chk(rd_req === 1'b1 && mem_wr_valid === 1'b0, "R11 request held", {62'd0, rd_req, mem_wr_valid}, 64'd2);
      rd_valid = 1'b1; rd_gpr_a = gpr[ra]; rd_gpr_b = gpr[rb]; rd_fpr = fpr[fs];
      @(posedge clk); @(negedge clk);
      rd_valid = 1'b0;
      chk(mem_wr_valid === 1'b1, "R11 store strobe", {63'd0, mem_wr_valid}, 64'd1);
      chk(mem_wr_addr === ea, "R3 R4 effective address", {32'd0, mem_wr_addr}, {32'd0, ea});
      chk(mem_wr_data === fpr[fs], "R5 raw data", mem_wr_data, fpr[fs]);
      chk(mem_wr_data[63:56] === fpr[fs][63:56], "R5 MSB byte at EA", {56'd0, mem_wr_data[63:56]}, {56'd0, fpr[fs][63:56]});
      chk(wb_valid === upd, "R6 writeback strobe", {63'd0, wb_valid}, {63'd0, upd});
      if (upd) chk(wb_idx === ra && wb_data === {32'd0, ea}, "R6 writeback value",
                   wb_data, {32'd0, ea});
      chk(resv_inv_valid === (ren & ract), "R9 invalidate strobe", {63'd0, resv_inv_valid}, {63'd0, ren & ract});
      if (ren & ract) chk(resv_inv_addr === ea, "R9 invalidate address", {32'd0, resv_inv_addr}, {32'd0, ea});
      chk((exc_illegal | exc_fp_unavail | exc_invalid_form) === 1'b0, "R4 no flag on store",
          {61'd0, exc_illegal, exc_fp_unavail, exc_invalid_form}, 64'd0);
    end
    @(negedge clk);
    chk({mem_wr_valid, wb_valid, resv_inv_valid, exc_illegal, exc_fp_unavail, exc_invalid_form, rd_req} === 7'd0,
        "R11 single-cycle outputs",
        {57'd0, mem_wr_valid, wb_valid, resv_inv_valid, exc_illegal, exc_fp_unavail, exc_invalid_form, rd_req}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [63:0] bases [4];
    logic [63:0] offs [4];
    logic [15:0] disps [4];
    logic [63:0] pats [4];
    logic [4:0]  ras [3];
    logic [31:0] bad [8];
    bases = '{64'd0, 64'h1000, 64'hFFFF_FFFF_FFFF_FFF8, 64'h1234_5678_0000_0003};
    offs  = '{64'd0, 64'd5, 64'h10, 64'hFFFF_FFFF_FFFF_FFFF};
    disps = '{16'h0000, 16'h0001, 16'h8000, 16'h7FFF};
    pats  = '{64'h7FF0_0000_0000_0001, 64'h8000_0000_0000_0000, 64'h0123_4567_89AB_CDEF, 64'hFFF8_0000_0000_0000};
    ras   = '{5'd0, 5'd1, 5'd31};
    bad   = '{32'h0000_0000, {6'd53, 26'h0}, {6'd56, 26'h0}, {6'd31, 15'h0, 10'd726, 1'b0},
              {6'd31, 15'h0, 10'd760, 1'b0}, {6'd31, 15'h0, 10'd727, 1'b1},
              {6'd31, 15'h0, 10'd759, 1'b1}, {6'd63, 26'h0}};
    for (int i = 0; i < 32; i++) begin
      gpr[i] = 64'hA5A5_0000_0000_0000 | 64'(i * 32'h0101);
      fpr[i] = {32'hC0DE_0000 | 32'(i), 32'(i) * 32'h1357_9BDF};
    end
    in_valid = 0; in_instr = 0; fp_en = 1; rd_valid = 0; rd_gpr_a = 0; rd_gpr_b = 0;
    rd_fpr = 0; resv_en = 0; resv_active = 0;
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk({mem_wr_valid, wb_valid, resv_inv_valid, exc_illegal, exc_fp_unavail, exc_invalid_form, rd_req} === 7'd0
        && in_ready === 1'b1, "R12 reset state",
        {56'd0, in_ready, mem_wr_valid, wb_valid, resv_inv_valid, exc_illegal, exc_fp_unavail, exc_invalid_form, rd_req},
        64'h80);

    for (int f = 0; f < 4; f++)
      for (int r = 0; r < 3; r++)
        for (int b = 0; b < 4; b++)
          for (int o = 0; o < 4; o++) begin
            logic [4:0] fs;
            fs = 5'((b * 7 + o * 3 + f) % 32);
            gpr[ras[r]] = bases[b];
            gpr[7] = offs[o];
            fpr[fs] = pats[(b + o) % 4];
            apply(f, mk(f, fs, ras[r], 5'd7, disps[o]), 1'b1, b[0], o[0]);
          end

    for (int f = 0; f < 4; f++) begin
      apply(f, mk(f, 5'd3, 5'd4, 5'd7, 16'h0010), 1'b0, 1'b1, 1'b1);   // R8
      apply(f, mk(f, 5'd3, 5'd0, 5'd7, 16'h0010), 1'b0, 1'b0, 1'b0);   // R8 over R7
    end
    for (int k = 0; k < 8; k++) begin
      apply(4, bad[k] | 32'h0004_2000, 1'b1, 1'b1, 1'b1);   // R10
      apply(4, bad[k], 1'b0, 1'b0, 1'b0);                    // R10 over R8
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule